// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a 32-bit processor bus and a byte-level serial transceiver. It decodes single-cycle word reads and writes in a 60-byte address window. It holds the control registers for transmit, DMA enable and receive, and an interrupt mask. It exposes a combined receive status and data word, a raw interrupt register, an acknowledge register and a masked interrupt view. Bit-level shifting and baud timing are outside the block: received bytes arrive on a valid/data pair, and bytes to send leave on a valid/data pair that is confirmed by an accept pulse.

Software reads the status word at one of two addresses. One address clears the data-available flag as a side effect and the other does not. Interrupts are cleared by writing ones to the acknowledge register. A byte written while the transmitter is busy is parked. An acknowledge of bit 0 releases it.

Top module: `ser_regblk`

## Requirements
- R1: After reset the status word reads 0x0140_0000 (transmitter ready at bit 24, transmitter idle at bit 22), irq_o is low and tx_valid_o is low.
- R2: A word access (req_i=1, word_i=1) decodes these offsets: transmit control 0x00, DMA enable 0x04, receive control 0x08 and mask 0x2c (all read/write). A write to 0x10 sends a byte. The status reads at 0x20 (clearing) and 0x24 (plain). The acknowledge register is at 0x30, raw interrupts at 0x34 and masked interrupts at 0x38. rdata_o is combinational during a read and zero otherwise. Accesses with word_i=0, accesses at or above 0x3c, and unmapped offsets change nothing and read zero.
- R3: An accepted received byte replaces status bits [7:0], sets data-available (status bit 16) and sets raw interrupt bit 3.
- R4: A read at 0x20 returns the status word and clears data-available on the following edge. A read at 0x24 leaves it set. A byte accepted in the same cycle keeps it set.
- R5: rx_ready_o equals receive-control bit 0 OR NOT raw bit 3. A byte offered while rx_ready_o is low is dropped.
- R6: A write to 0x10 while the transmitter is ready raises tx_valid_o for one cycle on the next cycle, with tx_data_o equal to wdata_i[7:0]. Ready and idle then read low until tx_ack_i. tx_ack_i sets raw bit 0.
- R7: A write to 0x30 clears every raw bit where the written value has a one, and the value is stored for readback. A set event in the same cycle wins over the clear.
- R8: The masked register reads raw AND mask, and irq_o is high exactly while it is nonzero.
- R9: A write to 0x10 while the transmitter is busy parks the byte. A later tx_ack_i sets ready but leaves idle low. An acknowledge write with bit 0 set then sends the parked byte, stores bit 0 as zero and does not clear raw bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 write, 0 read |
| word_i | input | 1 | 1 for a 32-bit access; byte accesses are ignored |
| addr_i | input | AW | Byte address within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the read cycle |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receiver will accept a byte |
| tx_valid_o | output | 1 | One-cycle transmit byte pulse |
| tx_data_o | output | 8 | Transmit byte |
| tx_ack_i | input | 1 | Transceiver finished the byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle that the transmit pulse is only ever seen while ready and idle are low, and that a serviced parked byte leaves nothing parked. They also check that an accepted byte lands in the status word with data-available set, that a clearing read drops data-available, and that an acknowledge clears its raw bits. Only the bench scenarios can show the decode of each offset and that byte and out-of-window accesses are ignored. The same holds for bytes dropped while the receiver is not ready, and for the order of a parked byte, the accept pulse and the acknowledge. A behavioural model compares rdata_o, irq_o, rx_ready_o and the transmit outputs on every clock.

// File: rtl/ser_regblk_pkg.sv
package ser_regblk_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned WIN_BYTES   = 60;
  localparam int unsigned N_CTRL      = 4;
  localparam int unsigned OFF_TXD     = 'h10;
  localparam int unsigned OFF_STAT_C  = 'h20;
  localparam int unsigned OFF_STAT_P  = 'h24;
  localparam int unsigned OFF_ACK     = 'h30;
  localparam int unsigned OFF_RAW     = 'h34;
  localparam int unsigned OFF_MASKED  = 'h38;
  // tx ctrl, dma enable, rx ctrl, mask
  localparam int unsigned CTRL_OFF [N_CTRL] = '{'h00, 'h04, 'h08, 'h2c};
  localparam int unsigned CTRL_RX  = 2;
  localparam int unsigned CTRL_MSK = 3;
  localparam int unsigned DAV_BIT     = 16;
  localparam int unsigned IDLE_BIT    = 22;
  localparam int unsigned RDY_BIT     = 24;
  localparam int unsigned TX_DONE_BIT = 0;
  localparam int unsigned RX_PEND_BIT = 3;
endpackage

// File: rtl/ser_rx.sv
module ser_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       en_i,
  input  logic       pend_i,
  input  logic       rd_clr_i,
  output logic       rx_ready_o,
  output logic       fire_o,
  output logic [7:0] data_o,
  output logic       dav_o
);
  logic [7:0] data_q;
  logic       dav_q;

  assign rx_ready_o = en_i | ~pend_i;
  assign fire_o     = rx_valid_i & rx_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dav_q  <= 1'b0;
    end else begin
      if (fire_o) data_q <= rx_data_i;
      if (fire_o)        dav_q <= 1'b1;
      else if (rd_clr_i) dav_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign dav_o  = dav_q;

  // R3
  rx_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (dav_q && data_q == $past(rx_data_i)));
  // R4
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !fire_o) |=> !dav_q);
endmodule

// File: rtl/ser_tx.sv
module ser_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       svc_req_i,
  input  logic       tx_ack_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       ready_o,
  output logic       idle_o,
  output logic       svc_o
);
  logic       ready_q, idle_q, pend_q, valid_q;
  logic [7:0] pdata_q, txd_q;
  logic       fire;
  logic [7:0] fire_data;

  assign svc_o     = svc_req_i & pend_q;
  assign fire      = (wr_i & ready_q) | svc_o;
  assign fire_data = svc_o ? pdata_q : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      idle_q  <= 1'b1;
      pend_q  <= 1'b0;
      pdata_q <= '0;
      valid_q <= 1'b0;
      txd_q   <= '0;
    end else begin
      valid_q <= fire;
      if (fire) txd_q <= fire_data;
      if (svc_o) pend_q <= 1'b0;
      else if (wr_i && !ready_q) begin
        pend_q  <= 1'b1;
        pdata_q <= wdata_i;
      end
      if (fire)          ready_q <= 1'b0;
      else if (tx_ack_i) ready_q <= 1'b1;
      if (fire)                     idle_q <= 1'b0;
      else if (tx_ack_i && !pend_q) idle_q <= 1'b1;
    end
  end

  assign tx_valid_o = valid_q;
  assign tx_data_o  = txd_q;
  assign ready_o    = ready_q;
  assign idle_o     = idle_q;

  // R6
  busy_on_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (!ready_q && !idle_q));
  // R9
  park_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |=> !pend_q);
endmodule

// File: rtl/ser_irq.sv
module ser_irq
  import ser_regblk_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          ack_we_i,
  input  logic [DW-1:0] ack_val_i,
  input  logic          svc_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] ack_o,
  output logic [DW-1:0] masked_o,
  output logic          irq_o
);
  logic [DW-1:0] raw_q, ack_q, keep, clr;

  always_comb begin
    keep = '1;
    keep[TX_DONE_BIT] = ~svc_i;
    clr = ack_we_i ? (ack_val_i & keep) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      ack_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | set_i;
      if (ack_we_i) ack_q <= ack_val_i & keep;
    end
  end

  assign raw_o    = raw_q;
  assign ack_o    = ack_q;
  assign masked_o = raw_q & mask_i;
  assign irq_o    = |masked_o;

  // R7
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && !(|(set_i & clr))) |=> ((raw_q & $past(clr)) == '0));
endmodule

// File: rtl/ser_regblk.sv
module ser_regblk
  import ser_regblk_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          word_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ack_i,
  output logic          irq_o
);
  logic          acc, wr, rd, wr_txd, wr_ack, rd_clr;
  logic [DW-1:0] ctrl_q [N_CTRL];
  logic [DW-1:0] raw, ack, masked, set_v, stat;
  logic          rx_fire, dav, tx_rdy, tx_idle, svc;
  logic [7:0]    rx_byte;

  assign acc    = req_i & word_i & (addr_i < AW'(WIN_BYTES));
  assign wr     = acc & we_i;
  assign rd     = acc & ~we_i;
  assign wr_txd = wr & (addr_i == AW'(OFF_TXD));
  assign wr_ack = wr & (addr_i == AW'(OFF_ACK));
  assign rd_clr = rd & (addr_i == AW'(OFF_STAT_C));

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q[g] <= '0;
      else if (wr && addr_i == AW'(CTRL_OFF[g])) ctrl_q[g] <= wdata_i;
    end
  end

  ser_rx i_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i,
    .en_i     (ctrl_q[CTRL_RX][0]),
    .pend_i   (raw[RX_PEND_BIT]),
    .rd_clr_i (rd_clr),
    .rx_ready_o,
    .fire_o   (rx_fire),
    .data_o   (rx_byte),
    .dav_o    (dav)
  );

  ser_tx i_tx (
    .clk_i, .rst_ni,
    .wr_i      (wr_txd),
    .wdata_i   (wdata_i[7:0]),
    .svc_req_i (wr_ack & wdata_i[0]),
    .tx_ack_i,
    .tx_valid_o, .tx_data_o,
    .ready_o   (tx_rdy),
    .idle_o    (tx_idle),
    .svc_o     (svc)
  );

  always_comb begin
    set_v = '0;
    set_v[RX_PEND_BIT] = rx_fire;
    set_v[TX_DONE_BIT] = tx_ack_i;
    stat = '0;
    stat[7:0]      = rx_byte;
    stat[DAV_BIT]  = dav;
    stat[IDLE_BIT] = tx_idle;
    stat[RDY_BIT]  = tx_rdy;
  end

  ser_irq i_irq (
    .clk_i, .rst_ni,
    .set_i     (set_v),
    .ack_we_i  (wr_ack),
    .ack_val_i (wdata_i),
    .svc_i     (svc),
    .mask_i    (ctrl_q[CTRL_MSK]),
    .raw_o     (raw),
    .ack_o     (ack),
    .masked_o  (masked),
    .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      for (int i = 0; i < N_CTRL; i++)
        if (addr_i == AW'(CTRL_OFF[i])) rdata_o = ctrl_q[i];
      if (addr_i == AW'(OFF_STAT_C) || addr_i == AW'(OFF_STAT_P)) rdata_o = stat;
      if (addr_i == AW'(OFF_ACK))    rdata_o = ack;
      if (addr_i == AW'(OFF_RAW))    rdata_o = raw;
      if (addr_i == AW'(OFF_MASKED)) rdata_o = masked;
    end
  end
endmodule

// File: tb/test_ser_regblk.sv
module test_ser_regblk;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, word = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready_o, tx_valid_o, irq_o;
  logic [7:0]  tx_data_o;
  logic        tx_ack = 0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_regblk #(.AW(8)) i_ser_regblk (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ack_i(tx_ack),
    .irq_o(irq_o)
  );

  // reference model state
  logic [31:0] m_txc, m_dma, m_rxc, m_mask, m_ack, m_raw;
  logic [7:0]  m_data, m_pdata, m_txd;
  logic        m_dav, m_rdy, m_idle, m_pend, m_txv;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read();
    logic [31:0] s;
    if (!(req && word && !we && addr < 8'h3c)) return '0;
    s = '0;
    s[7:0] = m_data; s[16] = m_dav; s[22] = m_idle; s[24] = m_rdy;
    case (addr)
      8'h00: return m_txc;
      8'h04: return m_dma;
      8'h08: return m_rxc;
      8'h2c: return m_mask;
      8'h20, 8'h24: return s;
      8'h30: return m_ack;
      8'h34: return m_raw;
      8'h38: return m_raw & m_mask;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_txc = '0; m_dma = '0; m_rxc = '0; m_mask = '0; m_ack = '0; m_raw = '0;
      m_data = '0; m_pdata = '0; m_txd = '0;
      m_dav = 0; m_rdy = 1; m_idle = 1; m_pend = 0; m_txv = 0;
    end else begin
      bit acc, wr, rd, rxf, svc, fired, n_pend;
      logic [31:0] clr;
      logic [7:0]  n_pdata;
      chk(rdata_o === m_read(), "R2 rdata", rdata_o, m_read());
      chk(irq_o === |(m_raw & m_mask), "R8 irq", {31'b0, irq_o}, {31'b0, |(m_raw & m_mask)});
      chk(rx_ready_o === (m_rxc[0] | ~m_raw[3]), "R5 rx_ready", {31'b0, rx_ready_o}, {31'b0, m_rxc[0] | ~m_raw[3]});
      chk(tx_valid_o === m_txv, "R6 tx_valid", {31'b0, tx_valid_o}, {31'b0, m_txv});
      if (m_txv) chk(tx_data_o === m_txd, "R6 tx_data", {24'b0, tx_data_o}, {24'b0, m_txd});
      acc = req && word && addr < 8'h3c;
      wr = acc && we;  rd = acc && !we;
      rxf = rx_valid && (m_rxc[0] || !m_raw[3]);
      svc = wr && addr == 8'h30 && wdata[0] && m_pend;
      fired = 0; n_pend = m_pend; n_pdata = m_pdata;
      m_txv = 0;
      if (wr && addr == 8'h10) begin
        if (m_rdy) begin fired = 1; m_txd = wdata[7:0]; end
        else begin n_pend = 1; n_pdata = wdata[7:0]; end
      end
      if (svc) begin fired = 1; m_txd = m_pdata; n_pend = 0; end
      if (fired) begin m_txv = 1; m_rdy = 0; m_idle = 0; end
      else if (tx_ack) begin m_rdy = 1; if (!m_pend) m_idle = 1; end
      m_pend = n_pend; m_pdata = n_pdata;
      clr = (wr && addr == 8'h30) ? (wdata & ~{31'b0, svc}) : '0;
      m_raw = (m_raw & ~clr) | {28'b0, rxf, 2'b0, tx_ack};
      if (wr && addr == 8'h30) m_ack = wdata & ~{31'b0, svc};
      if (rxf) begin m_data = rx_data; m_dav = 1; end
      else if (rd && addr == 8'h20) m_dav = 0;
      if (wr && addr == 8'h00) m_txc = wdata;
      if (wr && addr == 8'h04) m_dma = wdata;
      if (wr && addr == 8'h08) m_rxc = wdata;
      if (wr && addr == 8'h2c) m_mask = wdata;
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input bit w = 1);
    @(negedge clk); req = 1; we = 1; word = w; addr = a; wdata = d;
    @(posedge clk); #1; req = 0; we = 0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] m, input logic [31:0] e, input string tag);
    @(negedge clk); req = 1; we = 0; word = 1; addr = a;
    #1; chk((rdata_o & m) === e, tag, rdata_o & m, e);
    @(posedge clk); #1; req = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(posedge clk); #1; rx_valid = 0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); tx_ack = 1;
    @(posedge clk); #1; tx_ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk(irq_o === 0 && tx_valid_o === 0, "R1 irq/tx", {30'b0, irq_o, tx_valid_o}, 0);
    rd_expect(8'h24, '1, 32'h0140_0000, "R1 status");
    // R2 decode, ignored accesses
    bus_wr(8'h00, 32'hA5A5_0001);
    bus_wr(8'h04, 32'h3);
    rd_expect(8'h00, '1, 32'hA5A5_0001, "R2 txctrl");
    rd_expect(8'h04, '1, 32'h3, "R2 dma");
    bus_wr(8'h00, 32'h0, 0);
    rd_expect(8'h00, '1, 32'hA5A5_0001, "R2 byte write ignored");
    bus_wr(8'h3c, 32'hFFFF_FFFF);
    rd_expect(8'h3c, '1, 32'h0, "R2 outside window");
    // R3 / R5 receive
    rx_push(8'h5A);
    rd_expect(8'h24, '1, 32'h0141_005A, "R3 status");
    rd_expect(8'h34, '1, 32'h8, "R3 raw");
    @(negedge clk); chk(rx_ready_o === 0, "R5 not ready", {31'b0, rx_ready_o}, 0);
    rx_push(8'h77);
    rd_expect(8'h24, 32'hFF, 32'h5A, "R5 dropped");
    bus_wr(8'h08, 32'h1);
    @(negedge clk); chk(rx_ready_o === 1, "R5 enabled", {31'b0, rx_ready_o}, 1);
    rx_push(8'h77);
    // R4 clearing read
    rd_expect(8'h24, '1, 32'h0141_0077, "R4 plain keeps");
    rd_expect(8'h20, '1, 32'h0141_0077, "R4 clear read value");
    rd_expect(8'h24, '1, 32'h0140_0077, "R4 dav cleared");
    // R8 / R7 interrupts
    bus_wr(8'h2c, 32'h8);
    @(negedge clk); chk(irq_o === 1, "R8 irq high", {31'b0, irq_o}, 1);
    rd_expect(8'h38, '1, 32'h8, "R8 masked");
    bus_wr(8'h2c, 32'h0, 0);
    rd_expect(8'h2c, '1, 32'h8, "R2 byte mask ignored");
    bus_wr(8'h30, 32'h8);
    rd_expect(8'h34, '1, 32'h0, "R7 raw cleared");
    @(negedge clk); chk(irq_o === 0, "R7 irq low", {31'b0, irq_o}, 0);
    rd_expect(8'h30, '1, 32'h8, "R7 ack stored");
    // R6 transmit
    bus_wr(8'h10, 32'h1C3);
    @(negedge clk);
    chk(tx_valid_o === 1 && tx_data_o === 8'hC3, "R6 pulse", {23'b0, tx_valid_o, tx_data_o}, 32'h1C3);
    @(negedge clk); chk(tx_valid_o === 0, "R6 one cycle", {31'b0, tx_valid_o}, 0);
    rd_expect(8'h24, 32'h0140_0000, 32'h0, "R6 busy bits");
    ack_pulse();
    rd_expect(8'h24, 32'h0140_0000, 32'h0140_0000, "R6 ready again");
    rd_expect(8'h34, 32'h1, 32'h1, "R6 raw done");
    bus_wr(8'h30, 32'h1);
    // R9 parked byte
    bus_wr(8'h10, 32'h11);
    bus_wr(8'h10, 32'h22);
    @(negedge clk); chk(tx_valid_o === 0, "R9 parked no pulse", {31'b0, tx_valid_o}, 0);
    ack_pulse();
    rd_expect(8'h24, 32'h0140_0000, 32'h0100_0000, "R9 ready not idle");
    bus_wr(8'h30, 32'h1);
    @(negedge clk);
    chk(tx_valid_o === 1 && tx_data_o === 8'h22, "R9 parked sent", {23'b0, tx_valid_o, tx_data_o}, 32'h122);
    rd_expect(8'h30, '1, 32'h0, "R9 ack bit0 cleared");
    rd_expect(8'h34, 32'h1, 32'h1, "R9 raw kept");
    ack_pulse();
    bus_wr(8'h30, 32'h1);
    rd_expect(8'h34, 32'h1, 32'h0, "R7 raw0 cleared");
    rd_expect(8'h30, '1, 32'h1, "R7 ack readback");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule